// File: doc/BRIEF.md
# Eight-Register Bank Switcher

This block is the address-translation core of a game cartridge mapper. The host CPU programs it through a two-step write protocol inside the 0x8000–0x9FFF window. An even address stores a register index, and an odd address loads the indexed bank register. Eight bank registers hold the state. Two of them place 8 KB program ROM windows, and six of them place the pattern (character) ROM windows seen by the picture processor.

The program map is fixed and has no mode bits. Registers 6 and 7 place the two switchable 8 KB windows at 0x8000 and 0xA000. The upper 16 KB of CPU space always shows the last 16 KB of program ROM. On the picture side, the lower 4 KB of pattern space is split into two 2 KB windows driven by registers 0 and 1. The upper 4 KB is split into four 1 KB windows driven by registers 2 to 5.

A build-time option selects an alternate board wiring. In that wiring, picture-address bit 12 drives the top pattern-ROM address bit. This reaches 128 KB of pattern ROM, with each half of the ROM visible only in its matching half of pattern space. All translation is combinational; only the bank registers and the index register are clocked.

Top module: `octo_bank_mapper`

## Requirements
- R1: After reset the index register and all eight bank registers are 0. CPU 0x8000 and 0xA000 then both map to program offset 0x0000, and every pattern address in 0x1000–0x1FFF maps to pattern offset (ppu_addr_i & 0x3FF).
- R2: A write with cpu_addr_i in 0x8000–0x9FFF and cpu_addr_i[0]=0 loads data bits [2:0] into the index register. A write in the same window with cpu_addr_i[0]=1 loads all 8 data bits into the bank register named by the index. The index is kept, so repeated odd writes reload the same register.
- R3: For CPU 0x8000–0x9FFF, prg_addr_o = {reg6, cpu_addr_i[12:0]}. For 0xA000–0xBFFF, prg_addr_o = {reg7, cpu_addr_i[12:0]}. Each register is cut to its low PRG_ADDR_W-13 bits.
- R4: For CPU 0xC000–0xFFFF, prg_addr_o = {all ones, cpu_addr_i[13:0]}, which is the last 16 KB of program ROM, whatever the registers hold.
- R5: For pattern addresses 0x0000–0x07FF, the 1 KB bank is {reg0[7:1], ppu_addr_i[10]}. For 0x0800–0x0FFF, it is {reg1[7:1], ppu_addr_i[10]}. Bit 0 of registers 0 and 1 has no effect.
- R6: For pattern addresses 0x1000–0x1FFF, the 1 KB bank is register 2+ppu_addr_i[11:10]. In every case chr_addr_o = {bank, ppu_addr_i[9:0]}, cut to CHR_ADDR_W bits.
- R7: Writes with cpu_addr_i outside 0x8000–0x9FFF change neither the index nor any bank register.
- R8: With CHR_A12_TO_A16=1, chr_addr_o[CHR_ADDR_W-1] equals ppu_addr_i[12], and the top bank bit taken from the registers is discarded.
- R9: prg_ce_o is 1 exactly when cpu_addr_i[15] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_wr_i | input | 1 | CPU write strobe, sampled on the rising clock edge |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| ppu_addr_i | input | 13 | Picture-processor pattern address (0x0000–0x1FFF) |
| prg_ce_o | output | 1 | Program ROM select |
| prg_addr_o | output | PRG_ADDR_W | Program ROM address |
| chr_addr_o | output | CHR_ADDR_W | Pattern ROM address |

## Verification
A wrong bank register or a wrong index register does not show at once. It appears only when the CPU or picture address next falls in a window that the register drives, and it then shows as wrong upper address bits in that same cycle. The bench therefore loads each register and then probes its window. It also probes the neighbouring windows, to catch a misrouted index. After ignored writes and repeated data writes, it probes every window again, because a corrupted register would otherwise stay hidden until some later access.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned REG_CNT = 8;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned IDX_W   = $clog2(REG_CNT);

  typedef enum logic [IDX_W-1:0] {
    REG_CHR_2K_LO = 3'd0,
    REG_CHR_2K_HI = 3'd1,
    REG_CHR_1K_0  = 3'd2,
    REG_CHR_1K_1  = 3'd3,
    REG_CHR_1K_2  = 3'd4,
    REG_CHR_1K_3  = 3'd5,
    REG_PRG_8000  = 3'd6,
    REG_PRG_A000  = 3'd7
  } reg_idx_e;

  typedef logic [REG_CNT-1:0][REG_W-1:0] bank_file_t;
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
  import mapper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             odd_i,
  input  logic [REG_W-1:0] data_i,
  output logic [IDX_W-1:0] idx_o,
  output bank_file_t       bank_o
);
  logic [IDX_W-1:0] idx_q;
  bank_file_t       bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (wr_i && !odd_i) begin
      idx_q <= data_i[IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_q[g] <= '0;
      end else if (wr_i && odd_i && (idx_q == IDX_W'(g))) begin
        bank_q[g] <= data_i;
      end
    end
  end

  assign idx_o  = idx_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/prg_window.sv
module prg_window
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_ADDR_W = 17,
  localparam int unsigned BANK_W    = PRG_ADDR_W - 13
) (
  input  logic [14:0]           addr_i,
  input  logic [REG_W-1:0]      bank_lo_i,
  input  logic [REG_W-1:0]      bank_hi_i,
  output logic [PRG_ADDR_W-1:0] addr_o
);
  logic [BANK_W-1:0] bank;

  always_comb begin
    unique case (addr_i[14:13])
      2'b00:   bank = bank_lo_i[BANK_W-1:0];
      2'b01:   bank = bank_hi_i[BANK_W-1:0];
      2'b10:   bank = {{(BANK_W-1){1'b1}}, 1'b0};
      default: bank = '1;
    endcase
  end

  assign addr_o = {bank, addr_i[12:0]};
endmodule

// File: rtl/chr_window.sv
module chr_window
  import mapper_pkg::*;
#(
  parameter int unsigned CHR_ADDR_W     = 17,
  parameter bit          CHR_A12_TO_A16 = 1'b0,
  localparam int unsigned BANK_W        = CHR_ADDR_W - 10
) (
  input  logic [12:0]           addr_i,
  input  bank_file_t            bank_i,
  output logic [CHR_ADDR_W-1:0] addr_o
);
  logic [REG_W-1:0]  sel_reg;
  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    if (!addr_i[12]) begin
      idx     = addr_i[11] ? REG_CHR_2K_HI : REG_CHR_2K_LO;
      sel_reg = {bank_i[idx][REG_W-1:1], addr_i[10]};
    end else begin
      idx     = IDX_W'(REG_CHR_1K_0) + IDX_W'(addr_i[11:10]);
      sel_reg = bank_i[idx];
    end
  end

  if (CHR_A12_TO_A16) begin : g_a12_top
    assign bank = {addr_i[12], sel_reg[BANK_W-2:0]};
  end else begin : g_plain
    assign bank = sel_reg[BANK_W-1:0];
  end

  assign addr_o = {bank, addr_i[9:0]};
endmodule

// File: rtl/octo_bank_mapper.sv
module octo_bank_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_ADDR_W     = 17,
  parameter int unsigned CHR_ADDR_W     = 17,
  parameter bit          CHR_A12_TO_A16 = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_wr_i,
  input  logic [15:0]           cpu_addr_i,
  input  logic [7:0]            cpu_data_i,
  input  logic [12:0]           ppu_addr_i,
  output logic                  prg_ce_o,
  output logic [PRG_ADDR_W-1:0] prg_addr_o,
  output logic [CHR_ADDR_W-1:0] chr_addr_o
);
  logic             cfg_wr;
  logic [IDX_W-1:0] idx_q;
  bank_file_t       bank_q;

  // only 0x8000-0x9FFF decodes as configuration space
  assign cfg_wr   = cpu_wr_i && (cpu_addr_i[15:13] == 3'b100);
  assign prg_ce_o = cpu_addr_i[15];

  bank_regfile i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr),
    .odd_i  (cpu_addr_i[0]),
    .data_i (cpu_data_i),
    .idx_o  (idx_q),
    .bank_o (bank_q)
  );

  prg_window #(.PRG_ADDR_W(PRG_ADDR_W)) i_prg (
    .addr_i    (cpu_addr_i[14:0]),
    .bank_lo_i (bank_q[REG_PRG_8000]),
    .bank_hi_i (bank_q[REG_PRG_A000]),
    .addr_o    (prg_addr_o)
  );

  chr_window #(
    .CHR_ADDR_W     (CHR_ADDR_W),
    .CHR_A12_TO_A16 (CHR_A12_TO_A16)
  ) i_chr (
    .addr_i (ppu_addr_i),
    .bank_i (bank_q),
    .addr_o (chr_addr_o)
  );
endmodule

// File: rtl/octo_bank_mapper_chk.sv
module octo_bank_mapper_chk
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_ADDR_W     = 17,
  parameter int unsigned CHR_ADDR_W     = 17,
  parameter bit          CHR_A12_TO_A16 = 1'b0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cpu_wr_i,
  input logic [15:0]           cpu_addr_i,
  input logic [7:0]            cpu_data_i,
  input logic [12:0]           ppu_addr_i,
  input logic [PRG_ADDR_W-1:0] prg_addr_o,
  input logic [CHR_ADDR_W-1:0] chr_addr_o,
  input logic [IDX_W-1:0]      idx_q,
  input bank_file_t            bank_q
);
  logic in_win;
  assign in_win = cpu_addr_i[15:13] == 3'b100;

  AST_INDEX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && in_win && !cpu_addr_i[0] |=> idx_q == $past(cpu_data_i[IDX_W-1:0])); // R2

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && in_win && cpu_addr_i[0] |=> bank_q[$past(idx_q)] == $past(cpu_data_i)); // R2

  AST_OUTSIDE_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && !in_win |=> $stable(bank_q) && $stable(idx_q)); // R7

  AST_FIXED_TOP_16K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:14] == 2'b11 |->
      (&prg_addr_o[PRG_ADDR_W-1:14]) && prg_addr_o[13:0] == cpu_addr_i[13:0]); // R4

  AST_2K_A10_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ppu_addr_i[12] |-> chr_addr_o[10:0] == ppu_addr_i[10:0]); // R5

  AST_A12_DRIVES_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CHR_A12_TO_A16 |-> chr_addr_o[CHR_ADDR_W-1] == ppu_addr_i[12]); // R8
endmodule

bind octo_bank_mapper octo_bank_mapper_chk #(
  .PRG_ADDR_W     (PRG_ADDR_W),
  .CHR_ADDR_W     (CHR_ADDR_W),
  .CHR_A12_TO_A16 (CHR_A12_TO_A16)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_wr_i   (cpu_wr_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_data_i (cpu_data_i),
  .ppu_addr_i (ppu_addr_i),
  .prg_addr_o (prg_addr_o),
  .chr_addr_o (chr_addr_o),
  .idx_q      (idx_q),
  .bank_q     (bank_q)
);

// File: tb/test_octo_bank_mapper.sv
`timescale 1ns/1ps
module test_octo_bank_mapper;
  localparam int PW = 17;
  localparam int CW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [15:0]   cpu_addr = 16'h0;
  logic [7:0]    cpu_data = 8'h0;
  logic [12:0]   ppu_addr = 13'h0;
  logic          ce, ce_v;
  logic [PW-1:0] prg, prg_v;
  logic [CW-1:0] chr, chr_v;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  octo_bank_mapper i_octo_bank_mapper (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_addr_i(cpu_addr),
    .cpu_data_i(cpu_data), .ppu_addr_i(ppu_addr),
    .prg_ce_o(ce), .prg_addr_o(prg), .chr_addr_o(chr));

  octo_bank_mapper #(.CHR_A12_TO_A16(1'b1)) i_octo_bank_mapper_a16 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_addr_i(cpu_addr),
    .cpu_data_i(cpu_data), .ppu_addr_i(ppu_addr),
    .prg_ce_o(ce_v), .prg_addr_o(prg_v), .chr_addr_o(chr_v));

  // {index, value, probe cpu address, expected program address}
  localparam logic [43:0] VEC [6] = '{
    {3'd6, 8'h03, 16'h8123, 17'h06123},
    {3'd7, 8'h05, 16'hA456, 17'h0A456},
    {3'd6, 8'h1E, 16'h9FFF, 17'h1DFFF},
    {3'd7, 8'hFF, 16'hA000, 17'h1E000},
    {3'd6, 8'h01, 16'hC010, 17'h1C010},
    {3'd7, 8'h02, 16'hE020, 17'h1E020}
  };

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_reg(input logic [2:0] idx, input logic [7:0] val);
    bus_wr(16'h8000, {5'd0, idx});
    bus_wr(16'h8001, val);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic probe_prg(input string tag, input logic [15:0] a, input logic [PW-1:0] exp);
    cpu_addr = a; #1;
    chk(tag, 32'(prg), 32'(exp));
  endtask

  task automatic probe_chr(input string tag, input logic [12:0] a,
                           input logic [CW-1:0] exp, input logic [CW-1:0] exp_v);
    ppu_addr = a; #1;
    chk(tag, 32'(chr), 32'(exp));
    chk({tag, " variant"}, 32'(chr_v), 32'(exp_v));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    probe_prg("R1 prg 8000", 16'h8000, 17'h00000);
    probe_prg("R1 prg A000", 16'hA000, 17'h00000);
    probe_chr("R1 chr 1C05", 13'h1C05, 17'h00005, 17'h10005);
    // R9 chip enable
    cpu_addr = 16'h7FFF; #1; chk("R9 ce low", 32'(ce), 32'd0);
    cpu_addr = 16'h8000; #1; chk("R9 ce high", 32'(ce), 32'd1);

    // R3 R4 vector walk
    foreach (VEC[i]) begin
      set_reg(VEC[i][43:41], VEC[i][40:33]);
      probe_prg($sformatf("R3/R4 vec %0d", i), VEC[i][32:17], VEC[i][16:0]);
    end

    // R5 2 KB windows, bit 0 ignored
    set_reg(3'd0, 8'h05);
    set_reg(3'd1, 8'h0A);
    probe_chr("R5 reg0 lo", 13'h0000, 17'h01000, 17'h01000);
    probe_chr("R5 reg0 hi", 13'h0400, 17'h01400, 17'h01400);
    probe_chr("R5 reg0 end", 13'h07FF, 17'h017FF, 17'h017FF);
    probe_chr("R5 reg1 lo", 13'h0800, 17'h02800, 17'h02800);
    probe_chr("R5 reg1 hi", 13'h0C00, 17'h02C00, 17'h02C00);

    // R6 1 KB windows
    set_reg(3'd2, 8'h10);
    set_reg(3'd3, 8'h21);
    set_reg(3'd4, 8'h32);
    set_reg(3'd5, 8'h7F);
    probe_chr("R6 reg2", 13'h1000, 17'h04000, 17'h14000);
    probe_chr("R6 reg3", 13'h1403, 17'h08403, 17'h18403);
    probe_chr("R6 reg4", 13'h1800, 17'h0C800, 17'h1C800);
    probe_chr("R6 reg5", 13'h1FFF, 17'h1FFFF, 17'h1FFFF);

    // R8 upper register bit discarded in lower half
    set_reg(3'd0, 8'h45);
    probe_chr("R8 a12 low", 13'h0000, 17'h11000, 17'h01000);

    // R2 index held across repeated data writes
    bus_wr(16'h8000, 8'hFA);
    bus_wr(16'h8001, 8'h10);
    bus_wr(16'h9FFF, 8'h33);
    probe_chr("R2 repeat data", 13'h1000, 17'h0CC00, 17'h1CC00);

    // R7 writes outside the window
    bus_wr(16'hA000, 8'h06);
    bus_wr(16'hA001, 8'h00);
    bus_wr(16'hC001, 8'h00);
    bus_wr(16'h6001, 8'h00);
    bus_wr(16'h7FFF, 8'h00);
    probe_chr("R7 reg2 kept", 13'h1000, 17'h0CC00, 17'h1CC00);
    probe_prg("R7 reg6 kept", 16'h8123, 17'h02123);
    probe_prg("R7 reg7 kept", 16'hA123, 17'h04123);
    bus_wr(16'h9001, 8'h77);
    probe_chr("R7 index kept", 13'h1000, 17'h1DC00, 17'h1DC00);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0; #1; @(negedge clk); rst_n = 1'b1;
    probe_prg("R1 rereset prg", 16'h8123, 17'h00123);
    probe_chr("R1 rereset chr", 13'h1C00, 17'h00000, 17'h10000);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule